// File: doc/BRIEF.md
# Multi-Level Interrupt Priority Controller

This block gathers thirteen peripheral interrupt request lines into a 32-bit pending-status word. Each source owns a fixed bit in that word and a fixed processor priority. A 32-bit enable word chooses which pending bits may reach the processor. The block drives a 3-bit priority level, which is the highest level held by any enabled pending source. When no such source exists the level is 0.

The status word is driven by events. When a request line goes high its bit is set, and when the line goes low its bit is cleared. A line that stays steady changes nothing, so software may overwrite the status word at any time, for example to drop a bit whose line is still high. A separate write strobe from the storage-controller control register carries one DMA-enable bit. This strobe sets or clears the status bit that belongs to storage DMA. Software reaches both words over a simple 32-bit register bus. Reads are combinational and writes take effect at the clock edge.

Top module: `irq_lvl_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status word, the enable word and `iplOut` are all 0.
- R2: A rising edge on `srcReq[i]` sets one status bit. The index-to-bit map is: 0→7, 1→3, 2→2, 3→9, 4→10, 5→12, 6→5, 7→17, 8→21, 9→23, 10→26, 11→27, 12→28. The bit reads back as set after the clock edge that samples the new line value.
- R3: A falling edge on `srcReq[i]` clears the status bit of that source at the same clock edge.
- R4: A bus write to offset 0x7000 replaces the whole status word and a write to 0x7800 replaces the whole enable word. A read returns the word at that offset. A read of any other offset returns 0, and a write to any other offset changes neither word.
- R5: When `ctlWrEn` is high, status bit 26 is set if `ctlDmaOn` is 1 and cleared if it is 0. An edge on `srcReq[10]` in the same cycle takes precedence over this.
- R6: Sources 0–6 carry level 3, source 7 carries level 5, and sources 8–12 carry level 6. `iplOut` is the highest level among the sources that are both pending and enabled, or 0 if there are none.
- R7: `iplOut` is registered. It follows a change of the status or enable word one clock edge later.
- R8: A source whose enable bit is 0 does not contribute to `iplOut`, but its status bit is still recorded.
- R9: When a line edge and a bus write to the status word fall in the same cycle, the line edge decides that source's bit. The written value decides all other bits.
- R10: A request line held at a constant level has no effect. After software clears the bit of a held line, the bit stays clear until the line next rises.
- R11: Status bits that belong to no source (0, 1, 4, 6, 8, 11, 13–16, 18–20, 22, 24, 25, 29–31) never raise `iplOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| srcReq | input | 13 | Peripheral request lines, one per source index |
| busWrEn | input | 1 | Register-bus write strobe |
| busAddr | input | 16 | Register-bus byte offset |
| busWdata | input | 32 | Register-bus write data |
| busRdata | output | 32 | Register-bus read data (combinational) |
| ctlWrEn | input | 1 | Write strobe of the storage-controller control register |
| ctlDmaOn | input | 1 | DMA-enable bit carried with that write |
| iplOut | output | 3 | Processor interrupt priority level |

## Verification
The hardest case to reach is a collision: a request line changes in exactly the cycle in which software writes the status word. The bench sets up this collision by driving the line transition and the bus write in the same low phase of the clock. It does so in both directions: a rising line against a write of zeros, and a falling line against a write of ones. A second case is easy to get wrong. Software clears the bit of a line that stays high, and the bench then holds the line for several cycles to show that the bit does not come back until a fresh rising edge.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;

  localparam int DATA_W  = 32;
  localparam int LVL_W   = 3;
  localparam int NUM_SRC = 13;
  localparam int NUM_LVL = 3;

  // Status bit owned by each source index.
  function automatic int srcBitPos(input int idx);
    case (idx)
      0:       return 7;
      1:       return 3;
      2:       return 2;
      3:       return 9;
      4:       return 10;
      5:       return 12;
      6:       return 5;
      7:       return 17;
      8:       return 21;
      9:       return 23;
      10:      return 26;
      11:      return 27;
      default: return 28;
    endcase
  endfunction

  // Processor priority level requested by each source index.
  function automatic logic [LVL_W-1:0] srcLevel(input int idx);
    if (idx <= 6)      return 3'd3;
    else if (idx == 7) return 3'd5;
    else               return 3'd6;
  endfunction

  // Level by rank, rank 0 being the most urgent.
  function automatic logic [LVL_W-1:0] rankLevel(input int rank);
    case (rank)
      0:       return 3'd6;
      1:       return 3'd5;
      default: return 3'd3;
    endcase
  endfunction

  // All status bits that belong to sources of one level.
  function automatic logic [DATA_W-1:0] levelMask(input logic [LVL_W-1:0] lvl);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (srcLevel(i) == lvl) m[srcBitPos(i)] = 1'b1;
    return m;
  endfunction

  localparam int SCSI_DMA_IDX = 10;
  localparam int SCSI_DMA_BIT = srcBitPos(SCSI_DMA_IDX);

  // Strobes from control to datapath.
  typedef struct packed {
    logic [DATA_W-1:0] hwSet;
    logic [DATA_W-1:0] hwClr;
    logic              statusWr;
    logic              maskWr;
    logic              rdStatus;
    logic              rdMask;
  } strobe_t;

endpackage

// File: rtl/irq_lvl_ctl.sv
module irq_lvl_ctl
  import irq_lvl_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 16'h7000,
  parameter logic [ADDR_W-1:0] MASK_OFS   = 16'h7800
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               ctlWrEn,
  input  logic               ctlDmaOn,
  output strobe_t            strb
);

  logic [NUM_SRC-1:0] reqPrev;
  logic [NUM_SRC-1:0] reqRise;
  logic [NUM_SRC-1:0] reqFall;
  logic               dmaLineEvt;
  logic               hitStatus;
  logic               hitMask;

  // Previous line values, for transition detection.
  always_ff @(posedge clk) begin
    if (!rstN) reqPrev <= '0;
    else       reqPrev <= srcReq;
  end

  assign reqRise    = srcReq & ~reqPrev;
  assign reqFall    = ~srcReq & reqPrev;
  assign dmaLineEvt = reqRise[SCSI_DMA_IDX] | reqFall[SCSI_DMA_IDX];

  assign hitStatus = (busAddr == STATUS_OFS);
  assign hitMask   = (busAddr == MASK_OFS);

  always_comb begin
    strb = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (reqRise[i]) strb.hwSet[srcBitPos(i)] = 1'b1;
      if (reqFall[i]) strb.hwClr[srcBitPos(i)] = 1'b1;
    end
    // Control-register path: a real line edge on the same source wins.
    if (ctlWrEn && !dmaLineEvt) begin
      if (ctlDmaOn) strb.hwSet[SCSI_DMA_BIT] = 1'b1;
      else          strb.hwClr[SCSI_DMA_BIT] = 1'b1;
    end
    strb.statusWr = busWrEn && hitStatus;
    strb.maskWr   = busWrEn && hitMask;
    strb.rdStatus = hitStatus;
    strb.rdMask   = hitMask;
  end

endmodule

// File: rtl/irq_lvl_dp.sv
module irq_lvl_dp
  import irq_lvl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] statusQ,
  output logic [DATA_W-1:0] maskQ,
  output logic [LVL_W-1:0]  iplQ
);

  logic [DATA_W-1:0]  statusSw;
  logic [DATA_W-1:0]  statusNext;
  logic [DATA_W-1:0]  pending;
  logic [NUM_LVL-1:0] lvlHit;
  logic [LVL_W-1:0]   iplNext;

  // Software value first, then hardware events override per bit.
  assign statusSw   = strb.statusWr ? busWdata : statusQ;
  assign statusNext = (statusSw & ~strb.hwClr) | strb.hwSet;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
    end else begin
      statusQ <= statusNext;
      if (strb.maskWr) maskQ <= busWdata;
    end
  end

  assign pending = statusQ & maskQ;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    localparam logic [DATA_W-1:0] LMASK = levelMask(rankLevel(g));
    assign lvlHit[g] = |(pending & LMASK);
  end

  // Walk from least to most urgent so the most urgent hit is kept.
  always_comb begin
    iplNext = '0;
    for (int g = NUM_LVL - 1; g >= 0; g--)
      if (lvlHit[g]) iplNext = rankLevel(g);
  end

  always_ff @(posedge clk) begin
    if (!rstN) iplQ <= '0;
    else       iplQ <= iplNext;
  end

  always_comb begin
    if (strb.rdStatus)    busRdata = statusQ;
    else if (strb.rdMask) busRdata = maskQ;
    else                  busRdata = '0;
  end

endmodule

// File: rtl/irq_lvl_ctrl.sv
module irq_lvl_ctrl
  import irq_lvl_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 16'h7000,
  parameter logic [ADDR_W-1:0] MASK_OFS   = 16'h7800
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic               ctlWrEn,
  input  logic               ctlDmaOn,
  output logic [LVL_W-1:0]   iplOut
);

  strobe_t           strb;
  logic [DATA_W-1:0] statusQ;
  logic [DATA_W-1:0] maskQ;

  irq_lvl_ctl #(
    .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS), .MASK_OFS(MASK_OFS)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .busWrEn(busWrEn),
    .busAddr(busAddr), .ctlWrEn(ctlWrEn), .ctlDmaOn(ctlDmaOn), .strb(strb)
  );

  irq_lvl_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .busRdata(busRdata), .statusQ(statusQ), .maskQ(maskQ), .iplQ(iplOut)
  );

endmodule

// File: rtl/irq_lvl_chk.sv
module irq_lvl_chk
  import irq_lvl_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcReq,
  input logic               ctlWrEn,
  input logic               ctlDmaOn,
  input logic [DATA_W-1:0]  statusQ,
  input logic [DATA_W-1:0]  maskQ,
  input logic [LVL_W-1:0]   iplOut
);

  localparam logic [DATA_W-1:0] L6 = levelMask(3'd6);
  localparam logic [DATA_W-1:0] L5 = levelMask(3'd5);
  localparam logic [DATA_W-1:0] L3 = levelMask(3'd3);
  localparam logic [DATA_W-1:0] ALL_SRC = L6 | L5 | L3;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int BP = srcBitPos(i);
    // R2
    src_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) && $rose(srcReq[i]) |=> statusQ[BP]);
    // R3
    src_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) && $fell(srcReq[i]) |=> !statusQ[BP]);
  end

  // R5
  ctl_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && ctlWrEn && ctlDmaOn && $stable(srcReq[SCSI_DMA_IDX])
    |=> statusQ[SCSI_DMA_BIT]);
  // R5
  ctl_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && ctlWrEn && !ctlDmaOn && !srcReq[SCSI_DMA_IDX] && $stable(srcReq[SCSI_DMA_IDX])
    |=> !statusQ[SCSI_DMA_BIT]);
  // R6
  top_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusQ & maskQ & L6)) |=> (iplOut == 3'd6));
  // R11
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & maskQ & ALL_SRC) == '0) |=> (iplOut == 3'd0));
  // R6
  legal_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (iplOut == 3'd0) || (iplOut == 3'd3) || (iplOut == 3'd5) || (iplOut == 3'd6));

endmodule

bind irq_lvl_ctrl irq_lvl_chk u_chk (
  .clk(clk), .rstN(rstN), .srcReq(srcReq), .ctlWrEn(ctlWrEn),
  .ctlDmaOn(ctlDmaOn), .statusQ(statusQ), .maskQ(maskQ), .iplOut(iplOut)
);

// File: tb/sim_irq_lvl_ctrl.sv
module sim_irq_lvl_ctrl;

  localparam logic [15:0] ST = 16'h7000;
  localparam logic [15:0] MK = 16'h7800;

  logic        clk = 1'b0;
  logic        rstN;
  logic [12:0] srcReq;
  logic        busWrEn;
  logic [15:0] busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic        ctlWrEn;
  logic        ctlDmaOn;
  logic [2:0]  iplOut;

  int nChecks = 0;
  int nErr    = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  irq_lvl_ctrl u0 (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .ctlWrEn(ctlWrEn), .ctlDmaOn(ctlDmaOn), .iplOut(iplOut)
  );

  function automatic int expBit(input int idx);
    case (idx)
      0: return 7;   1: return 3;   2: return 2;   3: return 9;
      4: return 10;  5: return 12;  6: return 5;   7: return 17;
      8: return 21;  9: return 23;  10: return 26; 11: return 27;
      default: return 28;
    endcase
  endfunction

  function automatic logic [2:0] expLvl(input int idx);
    return (idx <= 6) ? 3'd3 : (idx == 7) ? 3'd5 : 3'd6;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWdata = d;
    tick();
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    busRead(ST, d); check("R1 status", d, 0);
    busRead(MK, d); check("R1 mask", d, 0);
    check("R1 ipl", {29'd0, iplOut}, 0);
  endtask

  task automatic t_each_source();
    logic [31:0] d;
    busWrite(MK, 32'hFFFF_FFFF);
    for (int i = 0; i < 13; i++) begin
      srcReq[i] = 1'b1;
      tick();
      busRead(ST, d); check("R2 set bit", d, 32'd1 << expBit(i));
      check("R7 ipl still old", {29'd0, iplOut}, 0);
      tick();
      check("R6 ipl level", {29'd0, iplOut}, {29'd0, expLvl(i)});
      srcReq[i] = 1'b0;
      tick();
      busRead(ST, d); check("R3 clear bit", d, 0);
      tick();
      check("R7 ipl back to 0", {29'd0, iplOut}, 0);
    end
  endtask

  task automatic t_priority_mask();
    logic [31:0] d;
    busWrite(MK, 32'hFFFF_FFFF);
    srcReq[0] = 1'b1; srcReq[7] = 1'b1; srcReq[9] = 1'b1;
    tick(); tick();
    check("R6 highest wins", {29'd0, iplOut}, 6);
    busWrite(MK, ~(32'd1 << 23));
    tick();
    check("R8 level6 masked", {29'd0, iplOut}, 5);
    busWrite(MK, 32'd1 << 7);
    tick();
    check("R8 only level3 enabled", {29'd0, iplOut}, 3);
    busWrite(MK, 32'd0);
    tick();
    check("R8 all masked", {29'd0, iplOut}, 0);
    busRead(ST, d);
    check("R8 status kept", d, (32'd1 << 7) | (32'd1 << 17) | (32'd1 << 23));
    srcReq = '0;
    tick();
  endtask

  task automatic t_regs();
    logic [31:0] d;
    busWrite(MK, 32'hA5A5_5A5A);
    busRead(MK, d); check("R4 mask rw", d, 32'hA5A5_5A5A);
    busWrite(ST, 32'h0F0F_0F0F);
    busRead(ST, d); check("R4 status rw", d, 32'h0F0F_0F0F);
    busWrite(16'h7004, 32'hFFFF_FFFF);
    busRead(ST, d); check("R4 stray write status", d, 32'h0F0F_0F0F);
    busRead(MK, d); check("R4 stray write mask", d, 32'hA5A5_5A5A);
    busRead(16'h7004, d); check("R4 stray read", d, 0);
    busWrite(ST, 0);
    busWrite(MK, 0);
  endtask

  task automatic t_unused_bits();
    busWrite(MK, 32'hFFFF_FFFF);
    busWrite(ST, 32'hE000_0013);
    tick();
    check("R11 unused bits", {29'd0, iplOut}, 0);
    busWrite(ST, 0);
  endtask

  task automatic t_ctl_write();
    logic [31:0] d;
    busWrite(MK, 32'hFFFF_FFFF);
    ctlWrEn = 1'b1; ctlDmaOn = 1'b1;
    tick();
    ctlWrEn = 1'b0;
    busRead(ST, d); check("R5 ctl set", d, 32'd1 << 26);
    tick();
    check("R5 ctl ipl", {29'd0, iplOut}, 6);
    ctlWrEn = 1'b1; ctlDmaOn = 1'b0;
    tick();
    ctlWrEn = 1'b0;
    busRead(ST, d); check("R5 ctl clear", d, 0);
    // line rise beats a clearing control write
    srcReq[10] = 1'b1; ctlWrEn = 1'b1; ctlDmaOn = 1'b0;
    tick();
    ctlWrEn = 1'b0;
    busRead(ST, d); check("R5 line beats ctl", d, 32'd1 << 26);
    srcReq[10] = 1'b0;
    tick();
    busWrite(MK, 0);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    srcReq[1] = 1'b1;
    busWrite(ST, 32'd0);
    busRead(ST, d); check("R9 rise vs write0", d, 32'd1 << 3);
    srcReq[1] = 1'b0;
    busWrite(ST, 32'hFFFF_FFFF);
    busRead(ST, d); check("R9 fall vs write1", d, ~(32'd1 << 3));
    busWrite(ST, 0);
  endtask

  task automatic t_held();
    logic [31:0] d;
    srcReq[2] = 1'b1;
    tick();
    busRead(ST, d); check("R10 held set", d, 32'd1 << 2);
    busWrite(ST, 0);
    busRead(ST, d); check("R10 sw clear", d, 0);
    tick(); tick(); tick();
    busRead(ST, d); check("R10 stays clear", d, 0);
    srcReq[2] = 1'b0;
    tick();
    busRead(ST, d); check("R10 fall on clear bit", d, 0);
    srcReq[2] = 1'b1;
    tick();
    busRead(ST, d); check("R10 fresh rise", d, 32'd1 << 2);
    srcReq[2] = 1'b0;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; srcReq = '0; busWrEn = 1'b0; busAddr = '0; busWdata = '0;
    ctlWrEn = 1'b0; ctlDmaOn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_each_source();
    t_priority_mask();
    t_regs();
    t_unused_bits();
    t_ctl_write();
    t_collision();
    t_held();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule